// File: doc/BRIEF.md
# Streaming Vector Length Resolver

This block holds a 4-bit length-request field written by software and turns it into the vector length the datapath actually uses. The field asks for a length of (field + 1) x 128 bits. The hardware can only run at power-of-two lengths from 128 to 2048 bits. The subset it supports is fixed by a 5-bit parameter mask, and that mask must have at least one bit set. A more privileged level may also be present, and it imposes its own effective length as a cap.

The resolved length is produced by combinational logic from the stored field. It applies three checks in a fixed order:
1. A request below the smallest supported size is raised to that size.
2. Otherwise, if the privileged level is present and the request is above its cap, the cap is used.
3. Otherwise, the request is rounded down to the nearest supported size.

A write to the field is visible in the resolved outputs in the cycle after the write edge, with no extra synchronization step. Software reads of the field always return the raw stored request, never the resolved value.

Top module: `svl_resolver`

## Requirements
- R1: The requested length is (rd_field + 1) x 128 bits. The field is 4 bits, so requests range from 128 to 2048 bits. Reset clears the field to 0.
- R2: Bit i of eff_size_oh stands for 128 << i bits, for i from 0 to 4. Exactly one bit is set at all times, and eff_len_bits equals the length of that bit.
- R3: When the request is below the smallest size enabled in SUPPORT_MASK, the result is that smallest size. This holds whatever the cap inputs say.
- R4: When upper_present is 1, the request is not below the minimum, and the request exceeds the cap, the result is the cap. Cap codes 0 to 4 mean 128 << code bits. Codes 5 to 7 are treated as 2048 bits. The cap is used even when it is not in SUPPORT_MASK.
- R5: In every other case, the result is the largest size enabled in SUPPORT_MASK (bit i stands for 128 << i) that does not exceed the request.
- R6: When upper_present is 0, upper_cap_code has no effect on the result.
- R7: rd_field returns the last value written, unchanged, whatever the resolved length is.
- R8: A write with wr_en high takes effect at that clock edge, and the outputs reflect it in the following cycle. With wr_en low, the field and the outputs hold, whatever wr_field carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the request field |
| wr_field | input | 4 | Value to store into the request field |
| upper_present | input | 1 | The more privileged level exists |
| upper_cap_code | input | 3 | Cap of the privileged level as a size index |
| rd_field | output | 4 | Raw stored request, for software reads |
| eff_len_bits | output | 12 | Resolved vector length in bits |
| eff_size_oh | output | 5 | Resolved length as a one-hot size code |

## Verification
Two clamps can both apply in the same cycle: raising a short request to the minimum, and lowering a long request to the cap. This happens when the cap sits below the smallest supported size. Vectors that pair a below-minimum request with such a cap must resolve to the minimum, while a request just above the minimum with the same cap must resolve to the cap, even though the cap is unsupported. A field write and a cap change can also coincide. The bench changes the cap inputs in the cycle the new field lands and judges the outputs one cycle after the write edge against a model computed from the requirements.

// File: rtl/svl_pkg.sv
`timescale 1ns/1ps
package svl_pkg;
    localparam int NUM_SIZES  = 5;
    localparam int FIELD_W    = 4;
    localparam int UNIT_W     = FIELD_W + 1;
    localparam int CODE_W     = 3;
    localparam int UNIT_SHIFT = 7;
    localparam int LEN_W      = UNIT_SHIFT + NUM_SIZES;

    typedef logic [NUM_SIZES-1:0] size_oh_t;

    typedef enum logic [1:0] {
        PICK_MIN   = 2'd0,
        PICK_CAP   = 2'd1,
        PICK_FLOOR = 2'd2
    } pick_e;

    // index of the smallest enabled size; the top index when none is set
    function automatic int lowest_index(input logic [NUM_SIZES-1:0] m);
        for (int i = 0; i < NUM_SIZES; i++) begin
            if (m[i]) return i;
        end
        return NUM_SIZES - 1;
    endfunction
endpackage

// File: rtl/svl_req_reg.sv
`timescale 1ns/1ps
module svl_req_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] field_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            field_q <= '0;
        end else if (wr_en) begin
            field_q <= wr_data;
        end
    end
endmodule

// File: rtl/svl_floor_pick.sv
`timescale 1ns/1ps
module svl_floor_pick
    import svl_pkg::*;
#(
    parameter logic [NUM_SIZES-1:0] MASK = 5'b01110
) (
    input  logic [UNIT_W-1:0] req_units,
    output size_oh_t          floor_oh,
    output size_oh_t          min_oh,
    output logic              below_min
);
    localparam int MIN_IDX = lowest_index(MASK);
    localparam logic [UNIT_W-1:0] MIN_UNITS = UNIT_W'(1 << MIN_IDX);

    logic [NUM_SIZES-1:0] fits;

    // one comparator per enabled size; disabled sizes never fit
    for (genvar i = 0; i < NUM_SIZES; i++) begin : g_fit
        localparam logic [UNIT_W-1:0] SZ = UNIT_W'(1 << i);
        if (MASK[i]) begin : g_on
            assign fits[i] = (req_units >= SZ);
        end else begin : g_off
            assign fits[i] = 1'b0;
        end
    end

    // later (larger) fitting sizes override earlier ones
    always_comb begin
        floor_oh = '0;
        for (int i = 0; i < NUM_SIZES; i++) begin
            if (fits[i]) floor_oh = size_oh_t'(1) << i;
        end
    end

    assign min_oh    = size_oh_t'(1) << MIN_IDX;
    assign below_min = (req_units < MIN_UNITS);
endmodule

// File: rtl/svl_cap_decode.sv
`timescale 1ns/1ps
module svl_cap_decode
    import svl_pkg::*;
(
    input  logic [CODE_W-1:0] cap_code,
    output size_oh_t          cap_oh,
    output logic [UNIT_W-1:0] cap_units
);
    always_comb begin
        cap_oh = '0;
        cap_oh[NUM_SIZES-1] = 1'b1;
        if (cap_code < CODE_W'(NUM_SIZES)) begin
            cap_oh = size_oh_t'(1) << cap_code;
        end
    end

    always_comb begin
        cap_units = '0;
        for (int i = 0; i < NUM_SIZES; i++) begin
            if (cap_oh[i]) cap_units = UNIT_W'(1 << i);
        end
    end
endmodule

// File: rtl/svl_clamp.sv
`timescale 1ns/1ps
module svl_clamp
    import svl_pkg::*;
(
    input  logic [UNIT_W-1:0] req_units,
    input  logic              below_min,
    input  size_oh_t          min_oh,
    input  logic              upper_present,
    input  size_oh_t          cap_oh,
    input  logic [UNIT_W-1:0] cap_units,
    input  size_oh_t          floor_oh,
    output size_oh_t          eff_oh
);
    pick_e pick;

    // fixed priority: minimum first, then cap, then round down
    always_comb begin
        if (below_min) begin
            pick = PICK_MIN;
        end else if (upper_present && (req_units > cap_units)) begin
            pick = PICK_CAP;
        end else begin
            pick = PICK_FLOOR;
        end
    end

    always_comb begin
        eff_oh = min_oh;
        unique case (pick)
            PICK_MIN:   eff_oh = min_oh;
            PICK_CAP:   eff_oh = cap_oh;
            PICK_FLOOR: eff_oh = floor_oh;
            default:    eff_oh = min_oh;
        endcase
    end
endmodule

// File: rtl/svl_resolver.sv
`timescale 1ns/1ps
module svl_resolver
    import svl_pkg::*;
#(
    parameter logic [NUM_SIZES-1:0] SUPPORT_MASK = 5'b01110
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [FIELD_W-1:0]  wr_field,
    input  logic                upper_present,
    input  logic [CODE_W-1:0]   upper_cap_code,
    output logic [FIELD_W-1:0]  rd_field,
    output logic [LEN_W-1:0]    eff_len_bits,
    output logic [NUM_SIZES-1:0] eff_size_oh
);
    logic [FIELD_W-1:0] field_q;
    logic [UNIT_W-1:0]  req_units;
    logic [UNIT_W-1:0]  cap_units;
    size_oh_t           floor_oh;
    size_oh_t           min_oh;
    size_oh_t           cap_oh;
    size_oh_t           eff_oh;
    logic               below_min;

    svl_req_reg #(.W(FIELD_W)) u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_field),
        .field_q (field_q)
    );

    assign req_units = {1'b0, field_q} + UNIT_W'(1);

    svl_floor_pick #(.MASK(SUPPORT_MASK)) u_floor (
        .req_units (req_units),
        .floor_oh  (floor_oh),
        .min_oh    (min_oh),
        .below_min (below_min)
    );

    svl_cap_decode u_cap (
        .cap_code  (upper_cap_code),
        .cap_oh    (cap_oh),
        .cap_units (cap_units)
    );

    svl_clamp u_clamp (
        .req_units     (req_units),
        .below_min     (below_min),
        .min_oh        (min_oh),
        .upper_present (upper_present),
        .cap_oh        (cap_oh),
        .cap_units     (cap_units),
        .floor_oh      (floor_oh),
        .eff_oh        (eff_oh)
    );

    always_comb begin
        eff_len_bits = '0;
        for (int i = 0; i < NUM_SIZES; i++) begin
            if (eff_oh[i]) eff_len_bits = eff_len_bits | LEN_W'((1 << UNIT_SHIFT) << i);
        end
    end

    assign rd_field    = field_q;
    assign eff_size_oh = eff_oh;
endmodule

// File: rtl/svl_resolver_chk.sv
`timescale 1ns/1ps
module svl_resolver_chk
    import svl_pkg::*;
#(
    parameter logic [NUM_SIZES-1:0] MASK = 5'b01110
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [FIELD_W-1:0]   wr_field,
    input logic                 upper_present,
    input logic [CODE_W-1:0]    upper_cap_code,
    input logic [FIELD_W-1:0]   rd_field,
    input logic [LEN_W-1:0]     eff_len_bits,
    input logic [NUM_SIZES-1:0] eff_size_oh
);
    localparam int MIN_IDX = lowest_index(MASK);
    localparam logic [LEN_W:0] MIN_LEN = (LEN_W+1)'(128 << MIN_IDX);

    logic [LEN_W:0] req_len;
    logic [LEN_W:0] cap_len;
    logic [LEN_W:0] eff_len;

    assign req_len = ((LEN_W+1)'(rd_field) + 1) << UNIT_SHIFT;
    assign cap_len = (upper_cap_code > 3'd4) ? (LEN_W+1)'(2048)
                                             : (LEN_W+1)'(128) << upper_cap_code;
    assign eff_len = {1'b0, eff_len_bits};

    AST_ONE_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(eff_size_oh) == 1);                                        // R2
    AST_MIN_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_len < MIN_LEN) |-> (eff_len == MIN_LEN));                        // R3
    AST_CAP_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        (upper_present && req_len >= MIN_LEN && req_len > cap_len) |-> (eff_len == cap_len)); // R4
    AST_NOT_ABOVE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_len >= MIN_LEN) |-> (eff_len <= req_len));                       // R5
    AST_NO_CAP_SUPPORTED: assert property (@(posedge clk) disable iff (!rst_n)
        (!upper_present) |-> ((eff_size_oh & MASK) != '0));                   // R6
    AST_RAW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en) |-> (rd_field == $past(wr_field)));                      // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en)) |-> $stable(rd_field));                               // R8
endmodule

bind svl_resolver svl_resolver_chk #(.MASK(SUPPORT_MASK)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .wr_field       (wr_field),
    .upper_present  (upper_present),
    .upper_cap_code (upper_cap_code),
    .rd_field       (rd_field),
    .eff_len_bits   (eff_len_bits),
    .eff_size_oh    (eff_size_oh)
);

// File: tb/svl_resolver_bench.sv
`timescale 1ns/1ps
module svl_resolver_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_field = 4'd0;
    logic       upper_present = 1'b0;
    logic [2:0] upper_cap_code = 3'd0;

    logic [3:0]  rd_a, rd_b, rd_c, rd_d;
    logic [11:0] len_a, len_b, len_c, len_d;
    logic [4:0]  oh_a, oh_b, oh_c, oh_d;

    int n_cmp = 0;
    int n_bad = 0;

    localparam logic [4:0] MASK_A = 5'b01110;
    localparam logic [4:0] MASK_B = 5'b11111;
    localparam logic [4:0] MASK_C = 5'b10101;
    localparam logic [4:0] MASK_D = 5'b00001;

    always #2.5 clk = ~clk;

    svl_resolver u_svl_resolver (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_field(wr_field),
        .upper_present(upper_present), .upper_cap_code(upper_cap_code),
        .rd_field(rd_a), .eff_len_bits(len_a), .eff_size_oh(oh_a));
    svl_resolver #(.SUPPORT_MASK(MASK_B)) u_full (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_field(wr_field),
        .upper_present(upper_present), .upper_cap_code(upper_cap_code),
        .rd_field(rd_b), .eff_len_bits(len_b), .eff_size_oh(oh_b));
    svl_resolver #(.SUPPORT_MASK(MASK_C)) u_sparse (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_field(wr_field),
        .upper_present(upper_present), .upper_cap_code(upper_cap_code),
        .rd_field(rd_c), .eff_len_bits(len_c), .eff_size_oh(oh_c));
    svl_resolver #(.SUPPORT_MASK(MASK_D)) u_single (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_field(wr_field),
        .upper_present(upper_present), .upper_cap_code(upper_cap_code),
        .rd_field(rd_d), .eff_len_bits(len_d), .eff_size_oh(oh_d));

    // {field[12:9], upper_present[8], cap_code[7:5], expected one-hot[4:0]} for MASK_A
    localparam logic [12:0] TBL [16] = '{
        {4'd0,  1'b0, 3'd0, 5'b00010},   // R3 below minimum
        {4'd0,  1'b1, 3'd0, 5'b00010},   // R3 minimum wins over a lower cap
        {4'd1,  1'b0, 3'd0, 5'b00010},   // R5 exact size
        {4'd2,  1'b0, 3'd0, 5'b00010},   // R5 round down
        {4'd3,  1'b0, 3'd0, 5'b00100},   // R5
        {4'd6,  1'b0, 3'd0, 5'b00100},   // R5
        {4'd7,  1'b0, 3'd0, 5'b01000},   // R5
        {4'd15, 1'b0, 3'd0, 5'b01000},   // R5 largest unsupported
        {4'd15, 1'b1, 3'd2, 5'b00100},   // R4 cap applies
        {4'd15, 1'b1, 3'd4, 5'b01000},   // R4 equal to cap, floor
        {4'd7,  1'b1, 3'd1, 5'b00010},   // R4
        {4'd7,  1'b1, 3'd3, 5'b01000},   // R4 request equals cap
        {4'd5,  1'b1, 3'd0, 5'b00001},   // R4 unsupported cap used
        {4'd15, 1'b0, 3'd0, 5'b01000},   // R6 cap ignored
        {4'd15, 1'b1, 3'd7, 5'b01000},   // R4 saturated cap code
        {4'd3,  1'b1, 3'd6, 5'b00100}    // R4 saturated cap code
    };

    function automatic logic [4:0] model(input logic [4:0] m, input logic [3:0] f,
                                         input logic up, input logic [2:0] c);
        int req;
        int lo;
        int capi;
        int best;
        req = int'(f) + 1;
        lo = 4;
        for (int i = 4; i >= 0; i--) if (m[i]) lo = i;
        if (req < (1 << lo)) return 5'(1 << lo);
        capi = (c > 3'd4) ? 4 : int'(c);
        if (up && req > (1 << capi)) return 5'(1 << capi);
        best = lo;
        for (int i = 0; i < 5; i++) if (m[i] && (1 << i) <= req) best = i;
        return 5'(1 << best);
    endfunction

    function automatic logic [11:0] oh_len(input logic [4:0] oh);
        logic [11:0] l;
        l = '0;
        for (int i = 0; i < 5; i++) if (oh[i]) l = 12'(128 << i);
        return l;
    endfunction

    task automatic check(input string tag, input logic [11:0] act_len, input logic [4:0] act_oh,
                         input logic [4:0] exp_oh);
        n_cmp++;
        if (act_oh !== exp_oh || act_len !== oh_len(exp_oh)) begin
            n_bad++;
            $display("FAIL %s: got len %0d oh %b, expected len %0d oh %b",
                     tag, act_len, act_oh, oh_len(exp_oh), exp_oh);
        end
    endtask

    task automatic check_raw(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got field %0d, expected %0d", tag, act, exp);
        end
    endtask

    task automatic write_field(input logic [3:0] f);
        @(negedge clk);
        wr_en = 1'b1;
        wr_field = f;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #500000;
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        summary();
        $finish;
    end

    initial begin
        // reset state: field 0, request 128 raised to minimum
        #3;
        check_raw("R1 reset field", rd_a, 4'd0);
        check("R1 reset length", len_a, oh_a, 5'b00010);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // table walk on the default mask
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            wr_en = 1'b1;
            wr_field = TBL[k][12:9];
            upper_present = TBL[k][8];
            upper_cap_code = TBL[k][7:5];
            @(negedge clk);
            wr_en = 1'b0;
            check_raw("R7 raw after table write", rd_a, TBL[k][12:9]);
            check("R3/R4/R5 table", len_a, oh_a, TBL[k][4:0]);
        end

        // full sweep on all masks against the model
        for (int f = 0; f < 16; f++) begin
            write_field(4'(f));
            for (int up = 0; up < 2; up++) begin
                for (int c = 0; c < 8; c++) begin
                    upper_present = up[0];
                    upper_cap_code = 3'(c);
                    #1;
                    check("R5 sweep default", len_a, oh_a, model(MASK_A, 4'(f), up[0], 3'(c)));
                    check("R5 sweep full",    len_b, oh_b, model(MASK_B, 4'(f), up[0], 3'(c)));
                    check("R4 sweep sparse",  len_c, oh_c, model(MASK_C, 4'(f), up[0], 3'(c)));
                    check("R3 sweep single",  len_d, oh_d, model(MASK_D, 4'(f), up[0], 3'(c)));
                end
            end
            check_raw("R7 raw sweep", rd_c, 4'(f));
        end

        // R6: cap code sweep with no privileged level leaves output unchanged
        upper_present = 1'b0;
        write_field(4'd11);
        for (int c = 0; c < 8; c++) begin
            upper_cap_code = 3'(c);
            #1;
            check("R6 cap ignored", len_c, oh_c, 5'b00100);
        end

        // R8: back-to-back writes, each visible the next cycle, cap changing alongside
        @(negedge clk);
        wr_en = 1'b1;
        wr_field = 4'd3;
        @(negedge clk);
        check("R8 first write", len_a, oh_a, 5'b00100);
        wr_field = 4'd0;
        upper_present = 1'b1;
        upper_cap_code = 3'd0;
        @(negedge clk);
        check("R8 second write", len_a, oh_a, 5'b00010);
        wr_field = 4'd15;
        upper_cap_code = 3'd2;
        @(negedge clk);
        check("R8 third write", len_a, oh_a, 5'b00100);
        check_raw("R7 raw under cap", rd_a, 4'd15);

        // R8: wr_en low ignores wr_field
        wr_en = 1'b0;
        upper_present = 1'b0;
        wr_field = 4'd0;
        @(negedge clk);
        @(negedge clk);
        check_raw("R8 hold field", rd_a, 4'd15);
        check("R8 hold length", len_a, oh_a, 5'b01000);
        check("R2 full mask max", len_b, oh_b, 5'b10000);

        summary();
        $finish;
    end
endmodule